// File: doc/BRIEF.md
# MESI Snooping Cache-Line Controller

This block holds the coherence state, tag and data word for each line of a small direct-mapped private cache, and keeps that cache coherent with its peers on a shared snooping bus. Processor accesses that hit with enough permission finish in the same cycle. All other accesses stall the processor and launch a single bus transaction: a read, a read-for-ownership, an upgrade, or a write-back of a dirty victim. When that transaction ends, the access is tried again.

In the same clock, the controller watches transactions that other caches put on the bus. A snooped address that matches a valid line can raise a shared indication, drive the line's data out as a flush when the line is dirty, and demote or invalidate the line. The line state uses a 2-bit code: Invalid 00, Shared 01, Exclusive 10, Modified 11. Bus operations use their own 2-bit code: read 00, read-for-ownership 01, upgrade 10, write-back 11.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After synchronous reset, every line is Invalid and `bus_req` is low. A snoop to any address then leaves `snp_shared` and `snp_flush` low, and the first processor access to any address issues a bus transaction.
- R2: A read that misses issues a read (`bus_cmd` 00) and returns the data delivered with `bus_done`. The line becomes Exclusive when `bus_shared` is low at `bus_done`, and Shared when it is high.
- R3: A write that misses issues a read-for-ownership (`bus_cmd` 01). The line ends Modified and holds the written data.
- R4: A write that hits a Shared line issues an upgrade (`bus_cmd` 10), after which the line is Modified.
- R5: A write that hits an Exclusive or Modified line completes with no bus transaction and leaves the line Modified.
- R6: A read that hits a Shared, Exclusive or Modified line completes with no bus transaction and returns the stored word.
- R7: Before a fill, a Modified victim is written back (`bus_cmd` 11) with its own address and data. An Exclusive or Shared victim is dropped with no bus traffic.
- R8: At most one transaction is outstanding. `bus_req` stays high with a stable command and address until `bus_gnt`, and `cpu_ready` stays low while a transaction is in progress.
- R9: A snooped read that hits a Modified line flushes the line's data and moves the line to Shared. A snooped read that hits an Exclusive line moves it to Shared with no flush. A Shared line stays Shared with no flush, so memory supplies the data.
- R10: A snooped read-for-ownership that hits a line invalidates it, and flushes the data first when the line is Modified.
- R11: A snooped upgrade that hits a line invalidates it with no flush.
- R12: `snp_shared` is high for a snooped read, read-for-ownership or upgrade that hits a valid line. A snoop whose tag differs from the stored tag, or that targets an Invalid line, has no effect.
- R13: While a snoop targets the same line index as the processor request, `cpu_ready` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Word address; the low bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Bus operation code |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Bus granted, one cycle |
| bus_done | input | 1 | Transaction finished, one cycle |
| bus_rdata | input | DATA_W | Fill data with `bus_done` |
| bus_shared | input | 1 | Another cache holds the line, sampled with `bus_done` |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped operation code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache drives dirty data for the snoop |
| snp_data | output | DATA_W | Flushed data, zero when no flush |

## Verification
The bench builds the block with 8-bit addresses, 16-bit words and four lines. With four lines, addresses that differ by four map to the same index, so dirty evictions, silent drops and write-back-then-refill sequences each take only a few accesses. The bus responder holds back each grant for two cycles, which exercises the requirement that a request stays stable while it waits. Snoops are aimed at lines in each of the four states to cover every downgrade and flush case.

// File: rtl/mesi_line_pkg.sv
`timescale 1ns / 1ps
package mesi_line_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_E = 2'b10,
        LN_M = 2'b11
    } line_st_t;

    typedef enum logic [1:0] {
        BT_RD  = 2'b00,
        BT_RDX = 2'b01,
        BT_UPG = 2'b10,
        BT_WB  = 2'b11
    } bus_op_t;

    typedef enum logic [1:0] {
        RQ_IDLE = 2'b00,
        RQ_ASK  = 2'b01,
        RQ_WAIT = 2'b10
    } req_ph_t;

    typedef struct packed {
        logic     hit;
        logic     flush;
        logic     upd;
        line_st_t nxt;
    } snp_act_t;

    // Reaction of one line to a transaction issued by another cache.
    function automatic snp_act_t snoop_react(line_st_t cur, bus_op_t op, logic tag_eq);
        snp_act_t a;
        a.hit   = tag_eq && (cur != LN_I) && (op != BT_WB);
        a.flush = 1'b0;
        a.upd   = 1'b0;
        a.nxt   = cur;
        if (a.hit) begin
            unique case (op)
                BT_RD: begin
                    a.flush = (cur == LN_M);
                    a.nxt   = LN_S;
                    a.upd   = (cur != LN_S);
                end
                BT_RDX: begin
                    a.flush = (cur == LN_M);
                    a.nxt   = LN_I;
                    a.upd   = 1'b1;
                end
                BT_UPG: begin
                    a.nxt   = LN_I;
                    a.upd   = 1'b1;
                end
                default: ;
            endcase
        end
        return a;
    endfunction

    // True when a hit in this state may complete locally.
    function automatic logic may_complete(line_st_t st, logic wr);
        return wr ? ((st == LN_E) || (st == LN_M)) : (st != LN_I);
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
`timescale 1ns / 1ps
module mesi_line_store
    import mesi_line_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      a_idx,
    output line_st_t              a_st,
    output logic [TAG_W-1:0]      a_tag,
    output logic [DATA_W-1:0]     a_data,
    input  logic [IDX_W-1:0]      b_idx,
    output line_st_t              b_st,
    output logic [TAG_W-1:0]      b_tag,
    output logic [DATA_W-1:0]     b_data,
    input  logic                  snp_we,
    input  line_st_t              snp_st,
    input  logic                  up_st_we,
    input  logic                  up_tag_we,
    input  logic                  up_data_we,
    input  logic [IDX_W-1:0]      up_idx,
    input  line_st_t              up_st,
    input  logic [TAG_W-1:0]      up_tag,
    input  logic [DATA_W-1:0]     up_data,
    output line_st_t [LINES-1:0]  st_vec
);

    line_st_t            st_q  [LINES];
    logic [TAG_W-1:0]    tag_q [LINES];
    logic [DATA_W-1:0]   dat_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_ln
        localparam logic [IDX_W-1:0] MY = IDX_W'(g);
        logic up_sel;
        logic sn_sel;
        assign up_sel = (up_idx == MY);
        assign sn_sel = (b_idx == MY);

        // Own-side updates take priority over snoop updates on the same line.
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g] <= LN_I;
            end else if (up_st_we && up_sel) begin
                st_q[g] <= up_st;
            end else if (snp_we && sn_sel) begin
                st_q[g] <= snp_st;
            end
            if (up_tag_we && up_sel) tag_q[g] <= up_tag;
            if (up_data_we && up_sel) dat_q[g] <= up_data;
        end

        assign st_vec[g] = st_q[g];
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = dat_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = dat_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns / 1ps
module mesi_snoop_unit
    import mesi_line_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              snp_valid,
    input  bus_op_t           snp_op,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              shared_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] fdata_o,
    output logic              wr_en,
    output line_st_t          wr_st
);

    snp_act_t act;

    always_comb act = snoop_react(ln_st, snp_op, snp_tag == ln_tag);

    assign shared_o = snp_valid && act.hit;
    assign flush_o  = snp_valid && act.flush;
    assign fdata_o  = flush_o ? ln_data : '0;
    assign wr_en    = snp_valid && act.upd;
    assign wr_st    = act.nxt;

endmodule

// File: rtl/mesi_req_ctrl.sv
`timescale 1ns / 1ps
module mesi_req_ctrl
    import mesi_line_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [IDX_W-1:0]        cpu_idx,
    input  logic [TAG_W-1:0]        cpu_tag,
    input  logic [DATA_W-1:0]       cpu_wdata,
    input  logic                    snp_clash,
    output logic [IDX_W-1:0]        look_idx,
    input  line_st_t                a_st,
    input  logic [TAG_W-1:0]        a_tag,
    input  logic [DATA_W-1:0]       a_data,
    output logic                    cpu_ready,
    output logic                    bus_req,
    output bus_op_t                 bus_op,
    output logic [TAG_W+IDX_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    input  logic                    bus_gnt,
    input  logic                    bus_done,
    input  logic [DATA_W-1:0]       bus_rdata,
    input  logic                    bus_shared,
    output logic                    up_st_we,
    output logic                    up_tag_we,
    output logic                    up_data_we,
    output logic [IDX_W-1:0]        up_idx,
    output line_st_t                up_st,
    output logic [TAG_W-1:0]        up_tag,
    output logic [DATA_W-1:0]       up_data
);

    req_ph_t            ph_q, ph_d;
    bus_op_t            op_q, op_d;
    logic [TAG_W-1:0]   btag_q, btag_d;
    logic [IDX_W-1:0]   bidx_q, bidx_d;
    logic [DATA_W-1:0]  bwd_q, bwd_d;
    logic               hit;
    logic               ok;

    assign look_idx  = (ph_q == RQ_IDLE) ? cpu_idx : bidx_q;
    assign hit       = (a_st != LN_I) && (a_tag == cpu_tag);
    assign ok        = hit && may_complete(a_st, cpu_we);
    assign cpu_ready = (ph_q == RQ_IDLE) && cpu_req && ok && !snp_clash;

    assign bus_req   = (ph_q == RQ_ASK);
    assign bus_op    = op_q;
    assign bus_addr  = {btag_q, bidx_q};
    assign bus_wdata = bwd_q;

    always_comb begin
        ph_d       = ph_q;
        op_d       = op_q;
        btag_d     = btag_q;
        bidx_d     = bidx_q;
        bwd_d      = bwd_q;
        up_st_we   = 1'b0;
        up_tag_we  = 1'b0;
        up_data_we = 1'b0;
        up_idx     = look_idx;
        up_st      = LN_I;
        up_tag     = btag_q;
        up_data    = cpu_wdata;
        unique case (ph_q)
            RQ_IDLE: begin
                if (cpu_req && !snp_clash) begin
                    if (ok) begin
                        if (cpu_we) begin
                            up_st_we   = 1'b1;
                            up_data_we = 1'b1;
                            up_st      = LN_M;
                        end
                    end else begin
                        ph_d   = RQ_ASK;
                        bidx_d = cpu_idx;
                        bwd_d  = a_data;
                        if (hit) begin
                            op_d   = BT_UPG;
                            btag_d = cpu_tag;
                        end else if (a_st == LN_M) begin
                            op_d   = BT_WB;
                            btag_d = a_tag;
                        end else begin
                            op_d     = cpu_we ? BT_RDX : BT_RD;
                            btag_d   = cpu_tag;
                            up_st_we = (a_st != LN_I);
                            up_st    = LN_I;
                        end
                    end
                end
            end
            RQ_ASK: begin
                if (bus_gnt) ph_d = RQ_WAIT;
            end
            RQ_WAIT: begin
                if (bus_done) begin
                    ph_d = RQ_IDLE;
                    unique case (op_q)
                        BT_WB: begin
                            up_st_we = 1'b1;
                            up_st    = LN_I;
                        end
                        BT_UPG: begin
                            up_st_we = (a_st == LN_S) && (a_tag == btag_q);
                            up_st    = LN_M;
                        end
                        BT_RD: begin
                            up_st_we   = 1'b1;
                            up_tag_we  = 1'b1;
                            up_data_we = 1'b1;
                            up_st      = bus_shared ? LN_S : LN_E;
                            up_data    = bus_rdata;
                        end
                        default: begin
                            up_st_we   = 1'b1;
                            up_tag_we  = 1'b1;
                            up_data_we = 1'b1;
                            up_st      = LN_M;
                            up_data    = bus_rdata;
                        end
                    endcase
                end
            end
            default: ph_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= RQ_IDLE;
            op_q   <= BT_RD;
            btag_q <= '0;
            bidx_q <= '0;
            bwd_q  <= '0;
        end else begin
            ph_q   <= ph_d;
            op_q   <= op_d;
            btag_q <= btag_d;
            bidx_q <= bidx_d;
            bwd_q  <= bwd_d;
        end
    end

    // R8: a waiting request keeps its operation and address until granted
    assert_bus_hold_R8: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_op) && $stable(bus_addr));

endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns / 1ps
module mesi_line_ctrl
    import mesi_line_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]     cpu_idx, snp_idx, look_idx, up_idx;
    logic [TAG_W-1:0]     cpu_tag, snp_tag, a_tag, b_tag, up_tag;
    logic [DATA_W-1:0]    a_data, b_data, up_data;
    line_st_t             a_st, b_st, up_st, snp_st;
    line_st_t [LINES-1:0] st_vec;
    logic                 snp_we, up_st_we, up_tag_we, up_data_we, snp_clash;
    bus_op_t              bus_op, snp_op;

    assign cpu_idx   = cpu_addr[IDX_W-1:0];
    assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[ADDR_W-1:IDX_W];
    assign snp_op    = bus_op_t'(snp_cmd);
    assign snp_clash = snp_valid && (snp_idx == cpu_idx);
    assign cpu_rdata = a_data;
    assign bus_cmd   = bus_op;

    mesi_line_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .a_idx(look_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .snp_we(snp_we), .snp_st(snp_st),
        .up_st_we(up_st_we), .up_tag_we(up_tag_we), .up_data_we(up_data_we),
        .up_idx(up_idx), .up_st(up_st), .up_tag(up_tag), .up_data(up_data),
        .st_vec(st_vec)
    );

    mesi_snoop_unit #(
        .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_snoop (
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_tag(snp_tag),
        .ln_st(b_st), .ln_tag(b_tag), .ln_data(b_data),
        .shared_o(snp_shared), .flush_o(snp_flush), .fdata_o(snp_data),
        .wr_en(snp_we), .wr_st(snp_st)
    );

    mesi_req_ctrl #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_req (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag),
        .cpu_wdata(cpu_wdata), .snp_clash(snp_clash), .look_idx(look_idx),
        .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .bus_shared(bus_shared),
        .up_st_we(up_st_we), .up_tag_we(up_tag_we), .up_data_we(up_data_we),
        .up_idx(up_idx), .up_st(up_st), .up_tag(up_tag), .up_data(up_data)
    );

    // R5: a completed write leaves its line Modified
    assert_write_sets_m_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_req && cpu_we && cpu_ready |=> st_vec[$past(cpu_idx)] == LN_M);

    // R9 / R10: a line that flushed is no longer Modified afterwards
    assert_flush_leaves_m_R9: assert property (@(posedge clk) disable iff (rst)
        snp_flush |=> st_vec[$past(snp_idx)] != LN_M);

    // R11: a snooped upgrade that hit leaves the line Invalid
    assert_upgrade_inval_R11: assert property (@(posedge clk) disable iff (rst)
        snp_valid && (snp_op == BT_UPG) && snp_shared |=> st_vec[$past(snp_idx)] == LN_I);

    // R13: a snoop on the requested index blocks completion
    assert_clash_stall_R13: assert property (@(posedge clk) disable iff (rst)
        snp_clash |-> !cpu_ready);

endmodule

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns / 1ps
module mesi_line_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_gnt = 1'b0, bus_done = 1'b0, bus_shared = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_shared, snp_flush;
    logic [15:0] snp_data;

    always #2.5 clk = ~clk;

    mesi_line_ctrl uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Memory model and bus responder
    logic [15:0] mem [256];
    int          ntx = 0;
    logic [1:0]  cmd0 = '0;
    logic        shr = 1'b0;
    int          gdelay = 2;
    int          wcnt = 0;
    logic        phase = 1'b0;
    logic [7:0]  pa;
    logic [1:0]  pc;
    logic [15:0] pw;

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = {8'hA5, 8'(a)};
        forever begin
            @(negedge clk);
            bus_gnt  = 1'b0;
            bus_done = 1'b0;
            if (phase) begin
                bus_done   = 1'b1;
                bus_shared = shr;
                bus_rdata  = mem[pa];
                if (pc == 2'b11) mem[pa] = pw;
                phase = 1'b0;
            end else if (bus_req && !rst) begin
                if (wcnt < gdelay) begin
                    wcnt++;
                end else begin
                    bus_gnt = 1'b1;
                    phase   = 1'b1;
                    wcnt    = 0;
                    pa = bus_addr;
                    pc = bus_cmd;
                    pw = bus_wdata;
                    if (ntx == 0) cmd0 = bus_cmd;
                    ntx++;
                    chk("R8 cpu_ready low while transaction open", {31'd0, cpu_ready}, 32'd0);
                end
            end
        end
    end

    task automatic access(input logic we, input logic [7:0] a, input logic [15:0] wd,
                          input logic s, output logic [15:0] rd);
        @(negedge clk);
        shr = s; ntx = 0; cmd0 = 2'b00;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        for (int k = 0; k < 300 && !cpu_ready; k++) begin
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] op, input logic [7:0] a, input logic esh,
                         input logic efl, input logic [15:0] edat, input string tg);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = op; snp_addr = a;
        #1;
        chk({tg, " snp_shared"}, {31'd0, snp_shared}, {31'd0, esh});
        chk({tg, " snp_flush"}, {31'd0, snp_flush}, {31'd0, efl});
        if (efl) begin
            chk({tg, " flush data"}, {16'd0, snp_data}, {16'd0, edat});
            if (snp_flush) mem[a] = snp_data;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic expect_access(input logic we, input logic [7:0] a, input logic [15:0] wd,
                                 input logic s, input int etx, input logic [1:0] ecmd,
                                 input logic [15:0] erd, input string tg);
        logic [15:0] rd;
        access(we, a, wd, s, rd);
        chk({tg, " transaction count"}, ntx, etx);
        if (etx > 0) chk({tg, " first command"}, {30'd0, cmd0}, {30'd0, ecmd});
        if (!we) chk({tg, " read data"}, {16'd0, rd}, {16'd0, erd});
    endtask

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [15:0] wd;
        logic        shr;
        logic [1:0]  ntx;
        logic [1:0]  cmd0;
        logic [15:0] rd;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h10, 16'h0000, 1'b0, 2'd1, 2'd0, 16'hA510}, // R1 R2 miss, alone -> E
        '{1'b1, 8'h10, 16'h1111, 1'b0, 2'd0, 2'd0, 16'h0000}, // R5 write E silently
        '{1'b0, 8'h10, 16'h0000, 1'b0, 2'd0, 2'd0, 16'h1111}, // R6 read hit M
        '{1'b0, 8'h14, 16'h0000, 1'b1, 2'd2, 2'd3, 16'hA514}, // R7 dirty victim, R2 -> S
        '{1'b1, 8'h14, 16'h2222, 1'b0, 2'd1, 2'd2, 16'h0000}, // R4 upgrade from S
        '{1'b0, 8'h11, 16'h0000, 1'b1, 2'd1, 2'd0, 16'hA511}, // R2 fill shared
        '{1'b0, 8'h15, 16'h0000, 1'b0, 2'd1, 2'd0, 16'hA515}, // R7 S victim dropped
        '{1'b1, 8'h16, 16'h3333, 1'b0, 2'd1, 2'd1, 16'h0000}, // R3 write miss
        '{1'b0, 8'h16, 16'h0000, 1'b0, 2'd0, 2'd0, 16'h3333}, // R3 R6 data kept
        '{1'b0, 8'h10, 16'h0000, 1'b0, 2'd2, 2'd3, 16'h1111}, // R7 write-back then refill
        '{1'b0, 8'h14, 16'h0000, 1'b0, 2'd1, 2'd0, 16'h2222}  // R7 E victim dropped
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
        snoop(2'b00, 8'h10, 1'b0, 1'b0, 16'h0, "R1 snoop after reset");

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].wd, VEC[i].shr, rd);
            chk($sformatf("vector %0d transaction count", i), ntx, 32'(VEC[i].ntx));
            if (VEC[i].ntx != 2'd0)
                chk($sformatf("vector %0d first command", i), {30'd0, cmd0}, {30'd0, VEC[i].cmd0});
            if (!VEC[i].we)
                chk($sformatf("vector %0d read data", i), {16'd0, rd}, {16'd0, VEC[i].rd});
        end
        gdelay = 0;

        // Lines now: idx0 0x14 E, idx1 0x15 E, idx2 0x16 M(3333), idx3 I
        snoop(2'b00, 8'h16, 1'b1, 1'b1, 16'h3333, "R9 read snoop on M");
        expect_access(1'b1, 8'h16, 16'h4444, 1'b0, 1, 2'b10, 16'h0, "R9 line is S after flush");
        snoop(2'b01, 8'h16, 1'b1, 1'b1, 16'h4444, "R10 ownership snoop on M");
        expect_access(1'b0, 8'h16, 16'h0, 1'b0, 1, 2'b00, 16'h4444, "R10 line invalidated");

        snoop(2'b00, 8'h15, 1'b1, 1'b0, 16'h0, "R9 read snoop on E");
        expect_access(1'b1, 8'h15, 16'h5555, 1'b0, 1, 2'b10, 16'h0, "R9 E became S");
        snoop(2'b00, 8'h15, 1'b1, 1'b1, 16'h5555, "R9 second flush");
        snoop(2'b00, 8'h15, 1'b1, 1'b0, 16'h0, "R9 clean S served by memory");
        snoop(2'b10, 8'h15, 1'b1, 1'b0, 16'h0, "R11 upgrade snoop");
        expect_access(1'b0, 8'h15, 16'h0, 1'b0, 1, 2'b00, 16'h5555, "R11 line invalidated");

        snoop(2'b01, 8'h18, 1'b0, 1'b0, 16'h0, "R12 tag mismatch");
        snoop(2'b00, 8'h13, 1'b0, 1'b0, 16'h0, "R12 invalid line");
        expect_access(1'b0, 8'h14, 16'h0, 1'b0, 0, 2'b00, 16'h2222, "R12 line untouched");

        // R13: snoop to the same index blocks the hit for that cycle
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'b00; snp_addr = 8'h18;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h14;
        #1;
        chk("R13 ready held low during same-index snoop", {31'd0, cpu_ready}, 32'd0);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk("R13 ready after snoop leaves", {31'd0, cpu_ready}, 32'd1);
        chk("R13 read data", {16'd0, cpu_rdata}, 32'h2222);
        @(negedge clk);
        cpu_req = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule